// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O data path behind a small synchronous register port. It has a direction register and a data register. Pins marked as outputs drive their data bit. Pins marked as inputs feed their external level into the data register.

The data register appears at every word address in the lower quarter of the address map. The word-address bits select which pins an access touches. Because the mask travels in the address, software can read or change any subset of pins in one access, with no read-modify-write sequence.

Each pin gets a registered resolved level, which is what the pin actually shows. An output pin shows its data bit. An input pin shows its pull configuration. A floating input pin holds the level it last showed. A one-cycle change strobe per pin marks every change of a resolved level. A fixed twelve-byte identification block sits at the top of the map.

Top module: `gpio_masked_port`

## Requirements
- R1: After synchronous reset, data and direction are 0x00, the change strobes are 0x00, the read data is 0 and every resolved pin level equals the pull-up parameter mask.
- R2: A read at word address W below 0x100 (byte offsets 0x000–0x3FF) returns the data register ANDed with W[7:0], which is bus_addr[9:2]. Read data appears on bus_rdata one cycle after the address is presented. bus_addr[1:0] is ignored everywhere.
- R3: A write at word address W below 0x100 changes only the data bits that are set both in W[7:0] and in the direction register. Every other output-pin data bit keeps its value.
- R4: The direction register is at byte offset 0x400 and holds wdata[7:0]. It reads back there. A 1 bit makes that pin an output.
- R5: Each clock, every data bit whose pin is an input (direction bit 0, as held before that edge) loads its pins_in level. Input levels on output pins are ignored.
- R6: The resolved level of a pin follows the first rule that applies. An output pin shows its data bit. An input pin with a pull-up shows 1. An input pin with a pull-down shows 0. Any other input pin keeps its previous resolved level.
- R7: pins_chg is set for exactly one cycle on each bit whose resolved level differs from its value one cycle earlier.
- R8: Byte offsets 0xFD0–0xFFC return the identification bytes in the low 8 bits, in order: 3C 91 07 00 52 1A 44 00 C3 5E A7 19. The first of these is at 0xFD0 and the last at 0xFFC.
- R9: Reads of any other offset return 0. Writes to them change no register.
- R10: pins_out and pins_chg are registered from the data and direction registers. A register write therefore reaches pins_out on the second clock edge after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| pins_in | input | 8 | External pin levels |
| pins_out | output | 8 | Registered resolved pin levels |
| pins_chg | output | 8 | One-cycle per-pin change strobe |

## Verification
A masked data write and the sampling of input pins can land on the same edge. A direction write can also coincide with an input change. The bench provokes both directly. It writes an alternating pattern through a full mask while opposite levels sit on pins_in, with the direction split so that half the pins are outputs. The readback must hold the written bits on output pins and the sampled bits on input pins, with the old direction governing that edge. Random traffic then mixes writes, reads and pin toggles in every cycle. A bench model, updated edge by edge, judges each cycle's read data, resolved levels and strobes.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

  localparam int PINS      = 8;
  localparam int ADDR_W    = 12;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int ID_COUNT  = 12;
  localparam logic [WORD_W-1:0] DIR_WORD = 10'h100;
  localparam logic [WORD_W-1:0] ID_BASE  = 10'h3F4;

  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_ID   = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  function automatic region_e decode(input logic [WORD_W-1:0] word);
    if (word[WORD_W-1:WORD_W-2] == 2'b00) return RGN_DATA;
    else if (word == DIR_WORD)            return RGN_DIR;
    else if (word >= ID_BASE)             return RGN_ID;
    else                                  return RGN_NONE;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h3C;
      4'd1:    return 8'h91;
      4'd2:    return 8'h07;
      4'd3:    return 8'h00;
      4'd4:    return 8'h52;
      4'd5:    return 8'h1A;
      4'd6:    return 8'h44;
      4'd7:    return 8'h00;
      4'd8:    return 8'hC3;
      4'd9:    return 8'h5E;
      4'd10:   return 8'hA7;
      4'd11:   return 8'h19;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
  import gpio_mp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  region_e         rgn,
  input  logic [PINS-1:0] amask,
  input  logic [PINS-1:0] wbyte,
  input  logic            we,
  input  logic [PINS-1:0] pins_in,
  output logic [PINS-1:0] data_q,
  output logic [PINS-1:0] dir_q
);

  logic            data_wr;
  logic [PINS-1:0] wmask;

  assign data_wr = we && (rgn == RGN_DATA);
  assign wmask   = data_wr ? (amask & dir_q) : '0;

  // Per-pin data bit: masked write on outputs, sampling on inputs.
  for (genvar i = 0; i < PINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[i] <= 1'b0;
      end else if (!dir_q[i]) begin
        data_q[i] <= pins_in[i];
      end else if (wmask[i]) begin
        data_q[i] <= wbyte[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (we && (rgn == RGN_DIR)) begin
      dir_q <= wbyte;
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> ((data_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

  // R5
  in_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((data_q & ~$past(dir_q)) == ($past(pins_in) & ~$past(dir_q))));

endmodule

// File: rtl/gpio_mp_resolve.sv
module gpio_mp_resolve
  import gpio_mp_pkg::*;
#(
  parameter logic [PINS-1:0] PULL_UP   = 8'hFF,
  parameter logic [PINS-1:0] PULL_DOWN = 8'h00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] data,
  input  logic [PINS-1:0] dir,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] chg_q
);

  if ((PULL_UP & PULL_DOWN) != '0) begin : g_bad_pull
    $error("pull-up and pull-down masks overlap");
  end

  logic [PINS-1:0] level_n;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      if (dir[i])            level_n[i] = data[i];
      else if (PULL_UP[i])   level_n[i] = 1'b1;
      else if (PULL_DOWN[i]) level_n[i] = 1'b0;
      else                   level_n[i] = out_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= PULL_UP;
      chg_q <= '0;
    end else begin
      out_q <= level_n;
      chg_q <= level_n ^ out_q;
    end
  end

  // R6
  drv_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_q & $past(dir)) == ($past(data) & $past(dir))));

  // R7
  chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chg_q == ($past(out_q) ^ out_q)));

endmodule

// File: rtl/gpio_mp_rdmux.sv
module gpio_mp_rdmux
  import gpio_mp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  region_e           rgn,
  input  logic [WORD_W-1:0] word,
  input  logic [PINS-1:0]   data,
  input  logic [PINS-1:0]   dir,
  output logic [DATA_W-1:0] rd_q
);

  logic [7:0]        sel;
  logic [WORD_W-1:0] id_off;

  assign id_off = word - ID_BASE;

  always_comb begin
    case (rgn)
      RGN_DATA: sel = data & word[PINS-1:0];
      RGN_DIR:  sel = dir;
      RGN_ID:   sel = id_byte(id_off[3:0]);
      default:  sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= {{(DATA_W-8){1'b0}}, sel};
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rgn == RGN_NONE) |=> (rd_q == '0));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mp_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [PINS-1:0] PULL_UP   = 8'hFF,
  parameter logic [PINS-1:0] PULL_DOWN = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        pins_in,
  output logic [7:0]        pins_out,
  output logic [7:0]        pins_chg
);

  logic [WORD_W-1:0] word;
  region_e           rgn;
  logic [PINS-1:0]   data_q;
  logic [PINS-1:0]   dir_q;

  assign word = bus_addr[ADDR_W-1:2];
  assign rgn  = decode(word);

  gpio_mp_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .rgn     (rgn),
    .amask   (word[PINS-1:0]),
    .wbyte   (bus_wdata[PINS-1:0]),
    .we      (bus_we),
    .pins_in (pins_in),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  gpio_mp_resolve #(
    .PULL_UP   (PULL_UP),
    .PULL_DOWN (PULL_DOWN)
  ) u_resolve (
    .clk   (clk),
    .rst   (rst),
    .data  (data_q),
    .dir   (dir_q),
    .out_q (pins_out),
    .chg_q (pins_chg)
  );

  gpio_mp_rdmux #(
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk  (clk),
    .rst  (rst),
    .rgn  (rgn),
    .word (word),
    .data (data_q),
    .dir  (dir_q),
    .rd_q (bus_rdata)
  );

endmodule

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb_top;

  localparam int         DATA_W = 32;
  localparam logic [7:0] PU     = 8'h0F;
  localparam logic [7:0] PD     = 8'h30;
  localparam logic [7:0] EXP_ID [12] = '{8'h3C, 8'h91, 8'h07, 8'h00, 8'h52, 8'h1A,
                                         8'h44, 8'h00, 8'hC3, 8'h5E, 8'hA7, 8'h19};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [11:0]       bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [7:0]        pins_in = '0;
  logic [7:0]        pins_out;
  logic [7:0]        pins_chg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]        m_data, m_dir, m_out, m_chg;
  logic [DATA_W-1:0] m_rd;

  always #2 clk = ~clk;

  gpio_masked_port #(.DATA_W(DATA_W), .PULL_UP(PU), .PULL_DOWN(PD)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pins_in(pins_in),
    .pins_out(pins_out), .pins_chg(pins_chg)
  );

  function automatic logic [DATA_W-1:0] exp_read(input logic [11:0] a,
                                                 input logic [7:0] d, input logic [7:0] r);
    logic [9:0] w = a[11:2];
    if (w < 10'h100)       return {{(DATA_W-8){1'b0}}, d & w[7:0]};
    else if (w == 10'h100) return {{(DATA_W-8){1'b0}}, r};
    else if (w >= 10'h3F4) return {{(DATA_W-8){1'b0}}, EXP_ID[w - 10'h3F4]};
    else                   return '0;
  endfunction

  function automatic logic [7:0] exp_level(input logic [7:0] d, input logic [7:0] r,
                                           input logic [7:0] prev);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      if (r[i])       v[i] = d[i];
      else if (PU[i]) v[i] = 1'b1;
      else if (PD[i]) v[i] = 1'b0;
      else            v[i] = prev[i];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [11:0] a, input logic [7:0] wd,
                      input logic we, input logic [7:0] pin);
    logic [7:0] wm, nd, nr, no;
    logic [DATA_W-1:0] nrd;
    bus_addr  = a;
    bus_wdata = {{(DATA_W-8){1'b0}}, wd};
    bus_we    = we;
    pins_in   = pin;
    nrd = exp_read(a, m_data, m_dir);
    no  = exp_level(m_data, m_dir, m_out);
    wm  = (we && a[11:10] == 2'b00) ? (a[9:2] & m_dir) : 8'h00;
    nd  = (m_data & m_dir & ~wm) | (wd & wm) | (pin & ~m_dir);
    nr  = (we && a[11:2] == 10'h100) ? wd : m_dir;
    @(posedge clk);
    @(negedge clk);
    m_chg = no ^ m_out;
    m_out = no; m_data = nd; m_dir = nr; m_rd = nrd;
    chk("R2 read path", bus_rdata, m_rd);
    chk("R6 resolved level", {24'h0, pins_out}, {24'h0, m_out});
    chk("R7 change strobe", {24'h0, pins_chg}, {24'h0, m_chg});
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] wd, input logic [7:0] pin);
    tick(a, wd, 1'b1, pin);
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] pin);
    tick(a, 8'h00, 1'b0, pin);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_data = 8'h00; m_dir = 8'h00; m_out = PU; m_chg = 8'h00; m_rd = '0;
    // R1 reset state
    chk("R1 pins_out", {24'h0, pins_out}, {24'h0, PU});
    chk("R1 pins_chg", {24'h0, pins_chg}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(12'h3FC, 8'h00); chk("R1 data", bus_rdata, 32'h0);
    rd(12'h400, 8'h00); chk("R1 dir", bus_rdata, 32'h0);
    // R4 direction register
    wr(12'h400, 8'hA5, 8'h00);
    rd(12'h402, 8'h00); chk("R4 dir readback", bus_rdata, 32'hA5);
    // R3 masked write gated by direction
    wr(12'h400, 8'h3C, 8'h00);
    wr(12'h3FC, 8'hFF, 8'h00);
    rd(12'h3FC, 8'h00); chk("R3 dir-gated write", bus_rdata, 32'h3C);
    wr(12'h400, 8'hFF, 8'h00);
    wr(12'h00C, 8'hFF, 8'h00);
    rd(12'h3FC, 8'h00); chk("R3 addr-masked write", bus_rdata, 32'h3F);
    // R2 masked read
    rd(12'h014, 8'h00); chk("R2 masked read", bus_rdata, 32'h05);
    rd(12'h000, 8'h00); chk("R2 empty mask", bus_rdata, 32'h00);
    // R10 latency to pins
    rd(12'h800, 8'h00);
    wr(12'h3FC, 8'h91, 8'h00);
    chk("R10 pins not yet", {24'h0, pins_out}, 32'h3F);
    rd(12'h800, 8'h00);
    chk("R10 pins updated", {24'h0, pins_out}, 32'h91);
    chk("R7 strobe bits", {24'h0, pins_chg}, 32'hAE);
    rd(12'h800, 8'h00);
    chk("R7 strobe one cycle", {24'h0, pins_chg}, 32'h00);
    // R6 pulls and floating hold
    wr(12'h400, 8'h00, 8'h00);
    rd(12'h800, 8'h00);
    chk("R6 pull/float levels", {24'h0, pins_out}, 32'h8F);
    // R5 inputs only on input pins
    wr(12'h400, 8'hF0, 8'h00);
    rd(12'h800, 8'hFF);
    rd(12'h3FC, 8'hFF); chk("R5 input sampling", bus_rdata, 32'h0F);
    // same-cycle write and sampling
    wr(12'h400, 8'h0F, 8'hFF);
    wr(12'h3FC, 8'hAA, 8'h55);
    rd(12'h3FC, 8'h55); chk("R3 R5 same cycle", bus_rdata, 32'h5A);
    // R8 identification bytes
    rd(12'hFD0, 8'h55); chk("R8 first id", bus_rdata, 32'h3C);
    rd(12'hFD4, 8'h55); chk("R8 second id", bus_rdata, 32'h91);
    rd(12'hFFC, 8'h55); chk("R8 last id", bus_rdata, 32'h19);
    // R9 unmapped
    wr(12'h800, 8'hFF, 8'h55);
    wr(12'h404, 8'hFF, 8'h55);
    rd(12'h400, 8'h55); chk("R9 write ignored", bus_rdata, 32'h0F);
    rd(12'h404, 8'h55); chk("R9 read zero", bus_rdata, 32'h00);
    rd(12'hFCC, 8'h55); chk("R9 below id", bus_rdata, 32'h00);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      int sel = $urandom % 8;
      case (sel)
        0, 1, 2, 3: a = 12'(($urandom % 256) * 4 + ($urandom % 4));
        4:          a = 12'h400;
        5:          a = 12'(12'hFD0 + ($urandom % 12) * 4);
        6:          a = 12'(12'h404 + ($urandom % 755) * 4);
        default:    a = 12'h3FC;
      endcase
      tick(a, 8'($urandom), ($urandom % 3) == 0, 8'($urandom));
    end
    finish_run();
  end

endmodule